// File: doc/BRIEF.md
# Feedback Digital Gain Controller

This block closes a digital automatic gain control loop around a complex baseband sample stream. For each valid I/Q sample it estimates the signal magnitude from the two components. It compares that estimate with a programmable reference and adjusts a gain word. The word is counted in half-decibel units, so every step is a fixed ratio and the loop behaves the same at any operating point. A downstream variable-gain stage takes the word directly.

Gain comes down fast and goes back up slowly. While the estimate is above the reference, every sample removes one attack step. Below the reference, the block waits for a run of weak samples before it adds one decay step. The gain word is always held inside a programmable window. The reference is normally set well under converter full scale, so the loop has headroom to act on a sudden rise in signal. A separate overload flag reports any sample that has actually reached full scale.

Top module: `agc_feedback`

## Requirements
- R1: While `rst_n` is low at a clock edge, `gain_code` is loaded with `cfg_gain_max` and `overload` is cleared.
- R2: For a sample taken with `valid_in` high at edge k, the level is M + floor(m/2), where M and m are the larger and the smaller of |I| and |Q|. This level is registered at edge k and compared with `cfg_ref` at edge k+1, which is also the edge at which `gain_code` changes.
- R3: If the level is strictly above `cfg_ref`, the gain falls by `cfg_attack` at edge k+1, subject to the R6 window.
- R4: Samples whose level is strictly below `cfg_ref` advance a pacing count. Every 2^DECAY_SHIFT-th such sample raises the gain by `cfg_decay`, subject to R6, and the count then wraps. With the default DECAY_SHIFT of 3, this happens on every 8th sample.
- R5: A sample above the reference clears the pacing count to zero. A sample exactly equal to the reference leaves both the count and the unclamped gain unchanged.
- R6: After every level update, `gain_code` lies within [`cfg_gain_min`, `cfg_gain_max`]. A value above the maximum is first cut to the maximum, and a value below the minimum is then raised to the minimum. This also applies when the window moves while the level stays equal to the reference.
- R7: `gain_code` does not change in a cycle that has no level update.
- R8: `overload` is high for the single cycle after edge k exactly when the sample taken at edge k had |I| or |Q| of at least 2^(SAMPLE_W-1)-1. Otherwise it is low.
- R9: One sample can both set `overload` (R8) and cause an attack step (R3). Each takes effect at its own edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| valid_in | input | 1 | Sample strobe |
| i_in | input | SAMPLE_W | In-phase sample, two's complement |
| q_in | input | SAMPLE_W | Quadrature sample, two's complement |
| cfg_ref | input | SAMPLE_W+1 | Target level, unsigned |
| cfg_attack | input | GAIN_W | Gain reduction per strong sample |
| cfg_decay | input | GAIN_W | Gain increase per paced weak run |
| cfg_gain_min | input | GAIN_W | Lower bound of gain code |
| cfg_gain_max | input | GAIN_W | Upper bound of gain code, reset value |
| gain_code | output | GAIN_W | Gain word, 0.5 dB per LSB |
| overload | output | 1 | Full-scale sample pulse |

## Verification
The two functions that can land on the same sample are the full-scale flag and a gain change. Both can also coincide with a clamp to a window edge. The bench sends full-scale samples, such as +2047 and -2048, while the level is above the reference, and repeats this with the gain already at the minimum. It expects the flag one cycle after the sample and the reduced or clamped gain one cycle after that. A scoreboard with separate queues for the flag and for the gain judges each output at its own edge.

// File: rtl/agc_pkg.sv
// Shared types for the feedback gain controller.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package agc_pkg;

    // Outcome of comparing the detected level with the reference.
    typedef enum logic [1:0] {
        LVL_BELOW = 2'd0,
        LVL_EQUAL = 2'd1,
        LVL_ABOVE = 2'd2
    } lvl_cmp_e;

endpackage

// File: rtl/agc_level_det.sv
// Level detector: converts one I/Q sample into an amplitude estimate
// max(|I|,|Q|) + min(|I|,|Q|)/2 and flags full-scale components.
// Assumes: two's complement inputs; outputs registered one cycle after valid.
module agc_level_det #(
    parameter int SAMPLE_W = 12,
    localparam int LVL_W   = SAMPLE_W + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                valid_in,
    input  logic [SAMPLE_W-1:0] i_in,
    input  logic [SAMPLE_W-1:0] q_in,
    output logic                lvl_vld,
    output logic [LVL_W-1:0]    level,
    output logic                overload
);

    localparam logic [LVL_W-1:0] FULL_SCALE = LVL_W'((1 << (SAMPLE_W - 1)) - 1);

    logic [LVL_W-1:0] mag_i, mag_q, mag_hi, mag_lo, level_d;
    logic             full_d;

    // Magnitudes computed at one extra bit so the most negative code fits.
    always_comb begin
        logic signed [LVL_W-1:0] ext_i, ext_q;
        ext_i = LVL_W'($signed(i_in));
        ext_q = LVL_W'($signed(q_in));
        mag_i = ext_i[LVL_W-1] ? LVL_W'(-ext_i) : LVL_W'(ext_i);
        mag_q = ext_q[LVL_W-1] ? LVL_W'(-ext_q) : LVL_W'(ext_q);
    end

    // Order the magnitudes, combine them and test for full scale.
    always_comb begin
        mag_hi  = (mag_i >= mag_q) ? mag_i : mag_q;
        mag_lo  = (mag_i >= mag_q) ? mag_q : mag_i;
        level_d = mag_hi + (mag_lo >> 1);
        full_d  = (mag_i >= FULL_SCALE) || (mag_q >= FULL_SCALE);
    end

    // Register the level, its strobe and the overload pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_vld  <= 1'b0;
            level    <= '0;
            overload <= 1'b0;
        end else begin
            lvl_vld  <= valid_in;
            overload <= valid_in && full_d;
            if (valid_in) begin
                level <= level_d;
            end
        end
    end

endmodule

// File: rtl/agc_decay_pacer.sv
// Decay pacer: counts weak samples and fires once per 2^DECAY_SHIFT of them.
// Assumes: a strong sample clears the count, an equal one leaves it alone.
module agc_decay_pacer
    import agc_pkg::*;
#(
    parameter int DECAY_SHIFT = 3
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     lvl_vld,
    input  lvl_cmp_e cmp,
    output logic     fire
);

    generate
        if (DECAY_SHIFT == 0) begin : g_every
            // No pacing: every weak sample fires.
            always_comb fire = lvl_vld && (cmp == LVL_BELOW);
        end else begin : g_count
            logic [DECAY_SHIFT-1:0] cnt;

            // A full count on a weak sample marks the paced step.
            always_comb fire = lvl_vld && (cmp == LVL_BELOW) && (&cnt);

            // Advance on weak samples, clear on strong ones.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt <= '0;
                end else if (lvl_vld) begin
                    if (cmp == LVL_ABOVE) begin
                        cnt <= '0;
                    end else if (cmp == LVL_BELOW) begin
                        cnt <= cnt + 1'b1;
                    end
                end
            end
        end
    endgenerate

endmodule

// File: rtl/agc_gain_loop.sv
// Gain loop: compares the level with the reference, applies attack or paced
// decay steps in 0.5 dB units and clamps the result to the gain window.
// Assumes: level already registered; the window may move at any time.
module agc_gain_loop
    import agc_pkg::*;
#(
    parameter int LVL_W  = 13,
    parameter int GAIN_W = 8,
    localparam int WIDE_W = GAIN_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lvl_vld,
    input  logic [LVL_W-1:0]  level,
    input  logic [LVL_W-1:0]  cfg_ref,
    input  logic [GAIN_W-1:0] cfg_attack,
    input  logic [GAIN_W-1:0] cfg_decay,
    input  logic [GAIN_W-1:0] cfg_gain_min,
    input  logic [GAIN_W-1:0] cfg_gain_max,
    input  logic              decay_fire,
    output lvl_cmp_e          cmp,
    output logic [GAIN_W-1:0] gain_code
);

    logic signed [WIDE_W-1:0] cand, lim_hi, lim_lo, clipped;

    // Classify the level against the reference.
    always_comb begin
        if (level > cfg_ref)       cmp = LVL_ABOVE;
        else if (level < cfg_ref)  cmp = LVL_BELOW;
        else                       cmp = LVL_EQUAL;
    end

    // Candidate gain in a wider signed range so no step wraps.
    always_comb begin
        cand = $signed(WIDE_W'(gain_code));
        if (cmp == LVL_ABOVE) begin
            cand = $signed(WIDE_W'(gain_code)) - $signed(WIDE_W'(cfg_attack));
        end else if (decay_fire) begin
            cand = $signed(WIDE_W'(gain_code)) + $signed(WIDE_W'(cfg_decay));
        end
    end

    // Cut to the maximum first, then raise to the minimum.
    always_comb begin
        lim_hi  = $signed(WIDE_W'(cfg_gain_max));
        lim_lo  = $signed(WIDE_W'(cfg_gain_min));
        clipped = (cand > lim_hi) ? lim_hi : cand;
        clipped = (clipped < lim_lo) ? lim_lo : clipped;
    end

    // Load the maximum on reset, update only on a level strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gain_code <= cfg_gain_max;
        end else if (lvl_vld) begin
            gain_code <= clipped[GAIN_W-1:0];
        end
    end

endmodule

// File: rtl/agc_feedback.sv
// Feedback gain controller top: level detector, decay pacer and gain loop.
// Assumes: synchronous active-low reset; config inputs quasi-static.
module agc_feedback
    import agc_pkg::*;
#(
    parameter int SAMPLE_W    = 12,
    parameter int GAIN_W      = 8,
    parameter int DECAY_SHIFT = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                valid_in,
    input  logic [SAMPLE_W-1:0] i_in,
    input  logic [SAMPLE_W-1:0] q_in,
    input  logic [SAMPLE_W:0]   cfg_ref,
    input  logic [GAIN_W-1:0]   cfg_attack,
    input  logic [GAIN_W-1:0]   cfg_decay,
    input  logic [GAIN_W-1:0]   cfg_gain_min,
    input  logic [GAIN_W-1:0]   cfg_gain_max,
    output logic [GAIN_W-1:0]   gain_code,
    output logic                overload
);

    localparam int LVL_W = SAMPLE_W + 1;

    logic             lvl_vld;
    logic [LVL_W-1:0] level;
    lvl_cmp_e         cmp;
    logic             decay_fire;

    agc_level_det #(.SAMPLE_W(SAMPLE_W)) u_det (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid_in (valid_in),
        .i_in     (i_in),
        .q_in     (q_in),
        .lvl_vld  (lvl_vld),
        .level    (level),
        .overload (overload)
    );

    agc_decay_pacer #(.DECAY_SHIFT(DECAY_SHIFT)) u_pacer (
        .clk     (clk),
        .rst_n   (rst_n),
        .lvl_vld (lvl_vld),
        .cmp     (cmp),
        .fire    (decay_fire)
    );

    agc_gain_loop #(.LVL_W(LVL_W), .GAIN_W(GAIN_W)) u_loop (
        .clk          (clk),
        .rst_n        (rst_n),
        .lvl_vld      (lvl_vld),
        .level        (level),
        .cfg_ref      (cfg_ref),
        .cfg_attack   (cfg_attack),
        .cfg_decay    (cfg_decay),
        .cfg_gain_min (cfg_gain_min),
        .cfg_gain_max (cfg_gain_max),
        .decay_fire   (decay_fire),
        .cmp          (cmp),
        .gain_code    (gain_code)
    );

endmodule

// File: rtl/agc_feedback_chk.sv
// Checker for agc_feedback: properties over ports and the level strobe.
// Assumes: bound into every agc_feedback instance.
module agc_feedback_chk #(
    parameter int LVL_W  = 13,
    parameter int GAIN_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              valid_in,
    input logic              lvl_vld,
    input logic [LVL_W-1:0]  level,
    input logic [LVL_W-1:0]  cfg_ref,
    input logic [GAIN_W-1:0] cfg_gain_min,
    input logic [GAIN_W-1:0] cfg_gain_max,
    input logic [GAIN_W-1:0] gain_code,
    input logic              overload
);

    assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !lvl_vld |=> $stable(gain_code));

    assert_no_rise_strong_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_vld && level > cfg_ref && cfg_gain_min <= cfg_gain_max
         && gain_code >= cfg_gain_min) |=> gain_code <= $past(gain_code));

    assert_no_fall_weak_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_vld && level < cfg_ref && cfg_gain_min <= cfg_gain_max
         && gain_code <= cfg_gain_max) |=> gain_code >= $past(gain_code));

    assert_in_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_vld && cfg_gain_min <= cfg_gain_max) |=>
        (gain_code >= $past(cfg_gain_min) && gain_code <= $past(cfg_gain_max)));

    assert_flag_follows_sample_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !valid_in) |=> !overload);

endmodule

bind agc_feedback agc_feedback_chk #(.LVL_W(SAMPLE_W + 1), .GAIN_W(GAIN_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .valid_in     (valid_in),
    .lvl_vld      (lvl_vld),
    .level        (level),
    .cfg_ref      (cfg_ref),
    .cfg_gain_min (cfg_gain_min),
    .cfg_gain_max (cfg_gain_max),
    .gain_code    (gain_code),
    .overload     (overload)
);

// File: tb/tb_agc_feedback.sv
`timescale 1ns/1ps
// Scoreboard bench for agc_feedback: the driver predicts the flag and the
// gain per sample; the monitor checks them at their own edges.
module tb_agc_feedback;

    localparam int SW = 12;
    localparam int GW = 8;
    localparam int DS = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          valid_in = 1'b0;
    logic [SW-1:0] i_in = '0, q_in = '0;
    logic [SW:0]   cfg_ref = 13'd1000;
    logic [GW-1:0] cfg_attack = 8'd6, cfg_decay = 8'd2;
    logic [GW-1:0] cfg_gain_min = 8'd20, cfg_gain_max = 8'd200;
    logic [GW-1:0] gain_code;
    logic          overload;

    int errors = 0;
    int checks = 0;
    bit mon_on = 1'b0;
    bit vd1 = 1'b0, vd2 = 1'b0;
    int m_gain, m_cnt, last_gain;
    bit ovl_q[$];
    int gain_q[$];
    int gtag_q[$];
    int cur_tag = 2;

    always #2 clk = ~clk;

    agc_feedback #(.SAMPLE_W(SW), .GAIN_W(GW), .DECAY_SHIFT(DS)) dut (
        .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .i_in(i_in), .q_in(q_in),
        .cfg_ref(cfg_ref), .cfg_attack(cfg_attack), .cfg_decay(cfg_decay),
        .cfg_gain_min(cfg_gain_min), .cfg_gain_max(cfg_gain_max),
        .gain_code(gain_code), .overload(overload)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Driver: present one sample and push the predicted outputs.
    task automatic send(input int i, input int q, input int tag);
        int ai, aq, hi, lo, lvl, cand, lim;
        @(negedge clk);
        i_in = SW'(i); q_in = SW'(q); valid_in = 1'b1;
        ai = (i < 0) ? -i : i;
        aq = (q < 0) ? -q : q;
        hi = (ai >= aq) ? ai : aq;
        lo = (ai >= aq) ? aq : ai;
        lvl = hi + lo / 2;
        lim = (1 << (SW - 1)) - 1;
        ovl_q.push_back((ai >= lim) || (aq >= lim));
        cand = m_gain;
        if (lvl > int'(cfg_ref)) begin
            cand = m_gain - int'(cfg_attack);
            m_cnt = 0;
        end else if (lvl < int'(cfg_ref)) begin
            if (m_cnt == (1 << DS) - 1) cand = m_gain + int'(cfg_decay);
            m_cnt = (m_cnt + 1) % (1 << DS);
        end
        if (cand > int'(cfg_gain_max)) cand = cfg_gain_max;
        if (cand < int'(cfg_gain_min)) cand = cfg_gain_min;
        m_gain = cand;
        gain_q.push_back(cand);
        gtag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            valid_in = 1'b0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        valid_in = 1'b0;
        rst_n = 1'b0;
        mon_on = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_gain = cfg_gain_max;
        m_cnt = 0;
        last_gain = cfg_gain_max;
        check(gain_code == cfg_gain_max, "R1 gain", gain_code, cfg_gain_max);
        check(overload == 1'b0, "R1 overload", overload, 0);
        mon_on = 1'b1;
    endtask

    // Monitor: track which edges carry a sample and a level update.
    always @(posedge clk) begin
        vd1 <= valid_in && rst_n;
        vd2 <= vd1 && rst_n;
    end

    always @(negedge clk) begin
        if (mon_on && rst_n) begin
            if (vd1) begin
                bit eo;
                eo = ovl_q.pop_front();
                check(overload == eo, "R8 overload", overload, eo);
            end else begin
                check(overload == 1'b0, "R8 idle overload", overload, 0);
            end
            if (vd2) begin
                int eg, tg;
                eg = gain_q.pop_front();
                tg = gtag_q.pop_front();
                check(gain_code == eg, $sformatf("R%0d gain", tg), gain_code, eg);
                last_gain = eg;
            end else begin
                check(gain_code == last_gain, "R7 hold", gain_code, last_gain);
            end
        end
    end

    initial begin
        #(4ns * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        do_reset();                                   // R1
        // R3: strong tone, steady attack.
        for (int k = 0; k < 10; k++) send(1500, 0, 3);
        idle(3);
        // R2: level formula, mixed signs, odd minor component, near ref.
        send(-800, 600, 2);   // 800+300 above
        send(600, -900, 2);   // 900+300 above
        send(700, 500, 2);    // 700+250 below
        send(1000, 0, 5);     // equal, R5
        send(0, -1000, 5);    // equal, R5
        send(5, 1999, 2);     // 1999+2 above
        send(1001, 1, 2);     // 1001 above
        send(999, 1, 2);      // 999 below
        idle(2);
        // R8 and R9: full-scale samples that also drive attack steps.
        send(2047, 0, 9);
        idle(1);
        send(0, -2048, 9);
        send(2046, -2046, 3);
        send(-2047, 3, 9);
        idle(3);
        // R4: weak tone, paced decay.
        for (int k = 0; k < 40; k++) send(100, 50, 4);
        idle(2);
        // R5: strong sample in the run restarts the pacing count.
        for (int k = 0; k < 5; k++) send(100, 0, 5);
        send(1200, 0, 5);
        for (int k = 0; k < 9; k++) send(100, 0, 5);
        idle(2);
        // R6: drive to floor, full scale at the floor (R9).
        for (int k = 0; k < 40; k++) send(1800, 1800, 6);
        send(2047, 2047, 9);
        idle(3);
        // R6: window moves under an equal-level stream.
        cfg_gain_min = 8'd50;
        idle(3);
        send(1000, 0, 6);
        idle(3);
        cfg_gain_max = 8'd40;
        idle(3);
        send(1000, 0, 6);
        idle(3);
        // R4/R6: climb to the top of a restored window.
        cfg_gain_min = 8'd20;
        cfg_gain_max = 8'd200;
        cfg_decay = 8'd7;
        idle(3);
        for (int k = 0; k < 220; k++) begin
            send(10, -10, 6);
            if (k % 37 == 0) idle(2);          // R7 gaps
        end
        idle(4);
        // R1: reset again after running.
        cfg_gain_max = 8'd180;
        idle(2);
        do_reset();
        send(1500, 0, 3);
        idle(4);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule